// File: doc/BRIEF.md
# Critical-Quadword-First Burst Sequencer

This block sends one 64-byte cache block over a 128-bit data path as four quadword beats. A requester gives a physical address, a transaction kind, the whole block and its eight ECC bytes in one request cycle. The block stores them and then sends the quadwords one per accepted beat on a valid/ready output channel. The beat order depends on the transaction kind.

For coherent reads and copybacks, the first quadword sent is the one that holds the requested address. For uncached reads and for writes, the block is aligned and the first quadword is always 0. In both cases, beat k carries quadword (start XOR k). This is an interleaved order, not a linear wrap. Each beat also carries its quadword index and two ECC sideband bytes, one for each 8-byte half. The block raises a one-cycle done pulse after the last beat is taken.

Top module: `qword_burst_seq`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the block becomes idle: `beat_valid`=0, `burst_done`=0, `req_ready`=1. This also applies in the middle of a burst.
- R2: A request is taken only at an edge where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the first beat to the last beat. A request raised in that window, together with its data, has no effect on the beats being sent, and it does not start a new burst.
- R3: For `req_type` 0 (coherent read) or 1 (copyback), the start index is `req_addr[5:4]`. Beat k carries `beat_qidx` = start XOR k, which gives the orders 0123, 1032, 2301 and 3210.
- R4: For `req_type` 2 (uncached read) or 3 (write), the beats always carry quadwords 0,1,2,3 in that order, whatever the address.
- R5: Address bits outside [5:4] have no effect on the beat order.
- R6: `beat_data` equals `req_data[q*128 +: 128]` as captured, where q = `beat_qidx`. Quadword byte b sits at bits [127-8b -: 8], so byte 0 is the most significant byte of the upper 64-bit half.
- R7: `beat_ecc_b07` equals `req_ecc[q*16+8 +: 8]`, the check byte for bytes 0–7. `beat_ecc_b815` equals `req_ecc[q*16 +: 8]`, the check byte for bytes 8–15.
- R8: The beat index advances only at an edge where `beat_valid` and `beat_ready` are both 1. While `beat_ready` is 0, the index, data and ECC bytes stay unchanged.
- R9: In the cycle after the fourth accepted beat, `burst_done` is 1 for exactly one cycle, `beat_valid` is 0 and `req_ready` is 1.
- R10: `beat_valid` rises in the cycle after the request is taken, and the first beat always has beat count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request can be taken |
| req_type | input | 2 | 0 coherent read, 1 copyback, 2 uncached read, 3 write |
| req_addr | input | 40 | Physical address of the request |
| req_data | input | 512 | Block data; quadword q at [q*128 +: 128] |
| req_ecc | input | 64 | ECC; quadword q at [q*16 +: 16], upper byte for bytes 0–7 |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Sink takes the beat |
| beat_data | output | 128 | Quadword data, big-endian bytes |
| beat_ecc_b07 | output | 8 | ECC byte for bytes 0–7 |
| beat_ecc_b815 | output | 8 | ECC byte for bytes 8–15 |
| beat_qidx | output | 2 | Index of the quadword on the bus |
| burst_done | output | 1 | One-cycle pulse after the last beat |

## Verification
Suppose the stored start index or the beat counter is wrong. `beat_qidx` and `beat_data` then differ from the XOR rule on the first beat after the fault, one cycle after the request or one edge after a handshake. Suppose the busy flag is wrong. That shows up in the same cycle as a missing or extra `req_ready`, or as a `burst_done` pulse on the wrong cycle. A stall cycle and a request raised in the middle of a burst show whether the stored state holds while nothing is being accepted.

// File: rtl/qseq_pkg.sv
// Shared types for the quadword burst sequencer.
// Assumes a 2-bit transaction code driven by the requester.
package qseq_pkg;
    typedef enum logic [1:0] {
        TXN_COH_RD   = 2'd0,
        TXN_COPYBACK = 2'd1,
        TXN_NC_RD    = 2'd2,
        TXN_WRITE    = 2'd3
    } txn_e;

    // Kinds that begin at the addressed quadword
    function automatic logic crit_first(input txn_e t);
        return (t == TXN_COH_RD) || (t == TXN_COPYBACK);
    endfunction
endpackage

// File: rtl/qseq_start_sel.sv
// Picks the first quadword of a burst from the quadword-select address bits
// and the transaction kind. Aligned kinds always begin at quadword 0.
// Assumes the caller passes only the quadword-select address field.
module qseq_start_sel #(
    parameter int QIDX_W = 2
) (
    input  logic [QIDX_W-1:0] qsel_bits,
    input  qseq_pkg::txn_e    txn,
    output logic [QIDX_W-1:0] start_idx
);
    // Critical-first kinds use the addressed quadword, the rest use zero
    always_comb start_idx = qseq_pkg::crit_first(txn) ? qsel_bits : '0;
endmodule

// File: rtl/qseq_beat_ctr.sv
// Burst control: busy flag, beat counter, stored start index and done pulse.
// The quadword index is start XOR count. Assumes load only while idle.
module qseq_beat_ctr #(
    parameter int QIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [QIDX_W-1:0] start_in,
    input  logic              beat_ready,
    output logic              busy,
    output logic [QIDX_W-1:0] cnt,
    output logic [QIDX_W-1:0] qidx,
    output logic              done
);
    localparam logic [QIDX_W-1:0] LAST = '1;

    logic              fire;
    logic [QIDX_W-1:0] start_q;

    // A beat is taken when presented and accepted
    always_comb fire = busy & beat_ready;

    // Interleaved index of the quadword currently presented
    always_comb qidx = start_q ^ cnt;

    // Advance burst state on load or on each accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            start_q <= '0;
            done    <= 1'b0;
        end else begin
            done <= fire && (cnt == LAST);
            if (load) begin
                busy    <= 1'b1;
                cnt     <= '0;
                start_q <= start_in;
            end else if (fire) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) busy <= 1'b0;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !beat_ready |=> busy && $stable(qidx) && $stable(cnt)); // R8
    AST_START_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(start_q)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_FIRST_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cnt == '0); // R10
    AST_XOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cnt != LAST |=> qidx == ($past(qidx) ^ $past(cnt) ^ cnt)); // R3
endmodule

// File: rtl/qseq_lane_mux.sv
// Selects one stored quadword and its two ECC bytes by quadword index.
// Assumes quadword q occupies slice q of the block and ECC vectors.
module qseq_lane_mux #(
    parameter int NUM_QW  = 4,
    parameter int QW_BITS = 128,
    parameter int ECC_W   = 8,
    parameter int QIDX_W  = 2
) (
    input  logic [NUM_QW*QW_BITS-1:0] blk,
    input  logic [NUM_QW*2*ECC_W-1:0] ecc,
    input  logic [QIDX_W-1:0]         sel,
    output logic [QW_BITS-1:0]        data,
    output logic [ECC_W-1:0]          ecc_b07,
    output logic [ECC_W-1:0]          ecc_b815
);
    logic [QW_BITS-1:0] qw_arr  [NUM_QW];
    logic [ECC_W-1:0]   eup_arr [NUM_QW];
    logic [ECC_W-1:0]   elo_arr [NUM_QW];

    // Unpack the flat vectors into one entry per quadword
    for (genvar g = 0; g < NUM_QW; g++) begin : g_unpack
        assign qw_arr[g]  = blk[g*QW_BITS +: QW_BITS];
        assign eup_arr[g] = ecc[g*2*ECC_W + ECC_W +: ECC_W];
        assign elo_arr[g] = ecc[g*2*ECC_W +: ECC_W];
    end

    // Route the selected quadword and its sideband bytes
    always_comb begin
        data     = qw_arr[sel];
        ecc_b07  = eup_arr[sel];
        ecc_b815 = elo_arr[sel];
    end
endmodule

// File: rtl/qword_burst_seq.sv
// Top of the burst sequencer. It captures a block request while idle and
// sends four quadword beats in critical-first or aligned order.
// Assumes the sink obeys valid/ready, and that the requester holds
// req_* stable only in the cycle it is taken.
module qword_burst_seq #(
    parameter int ADDR_W    = 40,
    parameter int BLK_BYTES = 64,
    parameter int QW_BYTES  = 16,
    parameter int ECC_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [1:0]                    req_type,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [BLK_BYTES*8-1:0]        req_data,
    input  logic [(BLK_BYTES/QW_BYTES)*2*ECC_W-1:0] req_ecc,
    output logic                          beat_valid,
    input  logic                          beat_ready,
    output logic [QW_BYTES*8-1:0]         beat_data,
    output logic [ECC_W-1:0]              beat_ecc_b07,
    output logic [ECC_W-1:0]              beat_ecc_b815,
    output logic [$clog2(BLK_BYTES/QW_BYTES)-1:0] beat_qidx,
    output logic                          burst_done
);
    localparam int NUM_QW   = BLK_BYTES / QW_BYTES;
    localparam int QIDX_W   = $clog2(NUM_QW);
    localparam int QW_BITS  = QW_BYTES * 8;
    localparam int OFFS_LSB = $clog2(QW_BYTES);
    localparam int ECC_ALL  = NUM_QW * 2 * ECC_W;

    logic                        busy;
    logic                        load;
    logic [QIDX_W-1:0]           start_idx;
    logic [QIDX_W-1:0]           cnt;
    logic [NUM_QW*QW_BITS-1:0]   blk_q;
    logic [ECC_ALL-1:0]          ecc_q;
    qseq_pkg::txn_e              txn;
    logic                        unused_addr_bits;

    // Address bits outside the quadword select do not steer the burst
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:OFFS_LSB+QIDX_W], req_addr[OFFS_LSB-1:0]};

    // Decode handshake and transaction kind
    always_comb begin
        txn        = qseq_pkg::txn_e'(req_type);
        req_ready  = !busy;
        load       = req_valid && !busy;
        beat_valid = busy;
    end

    qseq_start_sel #(.QIDX_W(QIDX_W)) start_i (
        .qsel_bits (req_addr[OFFS_LSB +: QIDX_W]),
        .txn       (txn),
        .start_idx (start_idx)
    );

    qseq_beat_ctr #(.QIDX_W(QIDX_W)) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_in   (start_idx),
        .beat_ready (beat_ready),
        .busy       (busy),
        .cnt        (cnt),
        .qidx       (beat_qidx),
        .done       (burst_done)
    );

    // Capture the block and its check bytes when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
            ecc_q <= '0;
        end else if (load) begin
            blk_q <= req_data;
            ecc_q <= req_ecc;
        end
    end

    qseq_lane_mux #(
        .NUM_QW (NUM_QW),
        .QW_BITS(QW_BITS),
        .ECC_W  (ECC_W),
        .QIDX_W (QIDX_W)
    ) mux_i (
        .blk      (blk_q),
        .ecc      (ecc_q),
        .sel      (beat_qidx),
        .data     (beat_data),
        .ecc_b07  (beat_ecc_b07),
        .ecc_b815 (beat_ecc_b815)
    );

    AST_CRIT_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_type < 2'd2 |=>
        beat_qidx == $past(req_addr[OFFS_LSB +: QIDX_W])); // R3
    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_type >= 2'd2 |=> beat_qidx == '0); // R4
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> $past(req_valid && req_ready)); // R10
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> $stable(beat_data) && $stable(beat_ecc_b07)); // R8
endmodule

// File: tb/qword_burst_seq_tb_top.sv
`timescale 1ns/1ps
module qword_burst_seq_tb_top;
    localparam int NV = 8;
    localparam logic [1:0]  V_TYPE  [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd3};
    localparam logic [39:0] V_ADDR  [NV] = '{40'h00_1000_0000, 40'h00_1000_001F,
                                             40'hAB_CDEF_01A7, 40'h00_0000_0038,
                                             40'h55_0000_00D5, 40'hFF_FFFF_FFFF,
                                             40'h00_2000_0025, 40'h00_2000_003C};
    localparam logic [1:0]  V_START [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd3, 2'd0, 2'd0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_type = 2'd0;
    logic [39:0]  req_addr = '0;
    logic [511:0] req_data = '0;
    logic [63:0]  req_ecc = '0;
    logic         beat_valid;
    logic         beat_ready = 1'b1;
    logic [127:0] beat_data;
    logic [7:0]   beat_ecc_b07;
    logic [7:0]   beat_ecc_b815;
    logic [1:0]   beat_qidx;
    logic         burst_done;
    int           errors = 0;
    int           checks = 0;
    bit           finished = 1'b0;

    always #2.5 clk = ~clk;

    qword_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_addr(req_addr), .req_data(req_data), .req_ecc(req_ecc),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
        .beat_ecc_b07(beat_ecc_b07), .beat_ecc_b815(beat_ecc_b815),
        .beat_qidx(beat_qidx), .burst_done(burst_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Quadword pattern with byte b at bits [127-8b -: 8]
    function automatic logic [127:0] qw_pat(input logic [7:0] seed, input int q);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[127-8*b -: 8] = seed ^ 8'(q*16 + b);
        return r;
    endfunction

    task automatic load_pattern(input logic [7:0] seed);
        for (int q = 0; q < 4; q++) begin
            req_data[q*128 +: 128] = qw_pat(seed, q);
            req_ecc[q*16+8 +: 8]   = 8'hE0 ^ seed ^ 8'(q);
            req_ecc[q*16 +: 8]     = 8'h70 ^ seed ^ 8'(q);
        end
    endtask

    task automatic run_burst(input logic [1:0] ty, input logic [39:0] ad, input logic [7:0] seed,
                             input logic [1:0] st, input int stall_k, input bit poke);
        logic [1:0] q;
        string ordtag;
        ordtag = (ty < 2'd2) ? "R3,R5 order" : "R4,R5 order";
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 idle before request", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_type = ty; req_addr = ad; load_pattern(seed); beat_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(beat_valid == 1'b1, "R10 valid after request", 128'(beat_valid), 128'd1);
        for (int k = 0; k < 4; k++) begin
            q = st ^ 2'(k);
            if (poke && k == 1) begin
                req_valid = 1'b1; req_type = 2'd3; req_addr = 40'h0;
                load_pattern(~seed);
            end
            chk(beat_valid == 1'b1, "R8 beat valid", 128'(beat_valid), 128'd1);
            chk(beat_qidx == q, ordtag, 128'(beat_qidx), 128'(q));
            chk(beat_data == qw_pat(seed, int'(q)), "R6 data", beat_data, qw_pat(seed, int'(q)));
            chk(beat_ecc_b07 == (8'hE0 ^ seed ^ 8'(q)), "R7 ecc bytes 0-7",
                128'(beat_ecc_b07), 128'(8'hE0 ^ seed ^ 8'(q)));
            chk(beat_ecc_b815 == (8'h70 ^ seed ^ 8'(q)), "R7 ecc bytes 8-15",
                128'(beat_ecc_b815), 128'(8'h70 ^ seed ^ 8'(q)));
            if (poke) chk(req_ready == 1'b0, "R2 busy not ready", 128'(req_ready), 128'd0);
            if (k == stall_k) begin
                beat_ready = 1'b0;
                @(negedge clk);
                chk(beat_valid == 1'b1, "R8 valid held in stall", 128'(beat_valid), 128'd1);
                chk(beat_qidx == q, "R8 index held in stall", 128'(beat_qidx), 128'(q));
                chk(beat_data == qw_pat(seed, int'(q)), "R8 data held in stall", beat_data, qw_pat(seed, int'(q)));
                beat_ready = 1'b1;
            end
            @(negedge clk);
        end
        if (poke) req_valid = 1'b0;
        chk(burst_done == 1'b1, "R9 done pulse", 128'(burst_done), 128'd1);
        chk(beat_valid == 1'b0, "R9 valid low at done", 128'(beat_valid), 128'd0);
        chk(req_ready == 1'b1, "R9 ready at done", 128'(req_ready), 128'd1);
        @(negedge clk);
        chk(burst_done == 1'b0, "R9 done one cycle", 128'(burst_done), 128'd0);
        if (poke) chk(beat_valid == 1'b0, "R2 busy request not started", 128'(beat_valid), 128'd0);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(beat_valid == 1'b0, "R1 reset valid", 128'(beat_valid), 128'd0);
        chk(burst_done == 1'b0, "R1 reset done", 128'(burst_done), 128'd0);
        chk(req_ready == 1'b1, "R1 reset ready", 128'(req_ready), 128'd1);
        rst_n = 1'b1;

        // Vector table: each kind and start index; R5 via junk low/high address bits
        for (int v = 0; v < NV; v++)
            run_burst(V_TYPE[v], V_ADDR[v], 8'(8'h11 * v), V_START[v], v % 5, 1'b0);

        // R2: request during a burst is ignored, its data does not leak
        run_burst(2'd0, 40'h00_0000_0020, 8'h5A, 2'd2, 9, 1'b1);

        // R1: reset in the middle of a burst
        @(negedge clk);
        req_valid = 1'b1; req_type = 2'd1; req_addr = 40'h30; load_pattern(8'h3C);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(beat_valid == 1'b0, "R1 mid-burst reset valid", 128'(beat_valid), 128'd0);
        chk(req_ready == 1'b1, "R1 mid-burst reset ready", 128'(req_ready), 128'd1);
        chk(burst_done == 1'b0, "R1 mid-burst reset done", 128'(burst_done), 128'd0);
        rst_n = 1'b1;

        // Fresh burst after reset still follows the rule
        run_burst(2'd1, 40'h00_0000_0030, 8'hC3, 2'd3, 0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule